// File: doc/BRIEF.md
# Video Input Timing Analyzer

This block watches a parallel video input (data enable, horizontal sync, vertical sync) sampled on a system clock. A pixel strobe `pix_en` marks each cycle that carries a pixel. From these signals the block measures:

- the active width and height,
- the polarity and pulse width of each sync,
- the four porch lengths.

All of these results are gathered into one status set. That set is refreshed together once per completed frame, so a reader always sees values that belong to the same frame.

A separate detector reports whether a live stream is present. It combines the externally supplied link-lock indication, a check that pixel strobes keep arriving, and a check that data enable keeps toggling.

The stream detector is a three-state machine:

- `LS_NOLINK`: lock is absent. It leaves to `LS_SEARCH` when `link_lock` rises.
- `LS_SEARCH`: locked, waiting for activity. It goes to `LS_STREAM` when activity is healthy and a data-enable edge arrives. It returns to `LS_NOLINK` on loss of lock.
- `LS_STREAM`: `stream_ok` is high. It falls back to `LS_SEARCH` when the pixel strobe stops or data enable stays quiet too long. It drops to `LS_NOLINK` on loss of lock.

Each sync is handled by its own probe. The probe infers polarity from which level the sync holds longest over one period. It declares the sync absent when no level change has been seen for more than twice the last measured period. Two span counters, one counting pixels and one counting lines, produce the porch and active lengths.

Top module: `vid_timing_probe`

## Requirements
- R1: `stream_ok` is 0 whenever `link_lock` was 0 on the previous clock. It stays 0 for as long as `link_lock` is 0, whatever the video does.
- R2: `stream_ok` falls once `de` has not changed for `de_quiet_max` pixel strobes. It rises again after `de` toggles with pixel strobes running.
- R3: `stream_ok` falls when no pixel strobe has arrived for `CLK_TIMEOUT` clock cycles. It returns once strobes and `de` activity resume.
- R4: `act_width` is the number of consecutive pixels with `de`=1 in a line. `act_height` is the number of consecutive lines that contain at least one `de`=1 pixel.
- R5: A present sync is reported with code 0 when its active level is low and code 1 when it is high. The active level is the level held for fewer samples over one period (pixels for horizontal sync, lines for vertical sync).
- R6: A sync is reported with code 2 (not available) in two cases: no full period has been seen since reset, or no level change has been seen for more than twice its last period in clock cycles. Code 3 is never produced.
- R7: `hs_width` is the horizontal sync pulse length in pixels. `vs_width` is the vertical sync pulse length in lines.
- R8: `h_back` counts the pixels between the end of horizontal sync and the first `de`=1 pixel. `h_front` counts the pixels between the last `de`=1 pixel and the start of horizontal sync.
- R9: `v_back` counts the lines between the end of vertical sync and the first line with `de`=1. `v_front` counts the lines between the last active line and the start of vertical sync.
- R10: All measurement outputs change only together, one cycle after the first line without `de` that follows the active lines of a frame. They hold between updates, even when the video stops. Their reset values are 0, with both sync codes at 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel strobe; the video inputs are sampled when it is high |
| link_lock | input | 1 | Link-lock indication from the receiver |
| de | input | 1 | Data enable |
| hsync | input | 1 | Horizontal sync, either polarity |
| vsync | input | 1 | Vertical sync, either polarity |
| de_quiet_max | input | QW | Pixel strobes without a `de` change before the stream is dropped |
| stream_ok | output | 1 | Stream detected |
| act_width | output | CNT_W | Active pixels per line |
| act_height | output | CNT_W | Active lines per frame |
| hs_code | output | 2 | Horizontal sync status: 0 low, 1 high, 2 absent |
| vs_code | output | 2 | Vertical sync status: 0 low, 1 high, 2 absent |
| hs_width | output | CNT_W | Horizontal sync width in pixels |
| vs_width | output | CNT_W | Vertical sync width in lines |
| h_back | output | CNT_W | Horizontal back porch in pixels |
| h_front | output | CNT_W | Horizontal front porch in pixels |
| v_back | output | CNT_W | Vertical back porch in lines |
| v_front | output | CNT_W | Vertical front porch in lines |

## Verification
The hardest situation to reach is a vertical sync that was running and then disappears. Frames must keep latching while the idle time grows past twice the measured frame period, so the change of the code to 2 is seen at a later frame boundary rather than at the moment the sync stops. The bench runs several normal frames first, then keeps generating complete frames with vertical sync frozen for longer than two frame periods. It checks that the vertical code becomes 2 while the active height stays correct. Stream loss is reached the same way, by three separate stimuli: a stalled data enable, a stopped pixel strobe, and dropped lock. Recovery is checked after each.

// File: rtl/vtp_pkg.sv
package vtp_pkg;

    typedef enum logic [1:0] {
        SYNC_LOW  = 2'd0,
        SYNC_HIGH = 2'd1,
        SYNC_NONE = 2'd2
    } sync_code_t;

    typedef enum logic [1:0] {
        LS_NOLINK = 2'd0,
        LS_SEARCH = 2'd1,
        LS_STREAM = 2'd2
    } link_state_t;

endpackage

// File: rtl/vtp_sync_probe.sv
// Polarity, pulse width and presence of one sync signal.
module vtp_sync_probe #(
    parameter int CNT_W = 12,
    parameter int PER_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             level,
    output logic             present,
    output logic             act_high,
    output logic [CNT_W-1:0] pulse_len
);
    localparam logic [CNT_W-1:0] CNT_ONE = 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [PER_W-1:0] PER_ONE = 1;
    localparam logic [PER_W-1:0] PER_MAX = '1;

    logic             seen_q, lvl_q, rise_seen_q, have_per_q;
    logic [CNT_W-1:0] hi_q, lo_q;
    logic [PER_W-1:0] per_cnt_q, per_q, idle_q;
    logic             rise, change;

    assign rise   = tick && seen_q && level && !lvl_q;
    assign change = tick && seen_q && (level != lvl_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            lvl_q       <= 1'b0;
            rise_seen_q <= 1'b0;
            have_per_q  <= 1'b0;
            hi_q        <= '0;
            lo_q        <= '0;
            per_cnt_q   <= '0;
            per_q       <= '0;
            idle_q      <= '0;
            act_high    <= 1'b0;
            pulse_len   <= '0;
        end else begin
            if (tick) begin
                seen_q <= 1'b1;
                lvl_q  <= level;
            end
            if (rise)
                per_cnt_q <= PER_ONE;
            else if (per_cnt_q != PER_MAX)
                per_cnt_q <= per_cnt_q + PER_ONE;
            if (change)
                idle_q <= '0;
            else if (idle_q != PER_MAX)
                idle_q <= idle_q + PER_ONE;
            if (rise) begin
                if (rise_seen_q) begin
                    per_q      <= per_cnt_q;
                    have_per_q <= 1'b1;
                    act_high   <= (hi_q <= lo_q);
                    pulse_len  <= (hi_q <= lo_q) ? hi_q : lo_q;
                end
                rise_seen_q <= 1'b1;
                hi_q        <= CNT_ONE;
                lo_q        <= '0;
            end else if (tick) begin
                if (level) begin
                    if (hi_q != CNT_MAX) hi_q <= hi_q + CNT_ONE;
                end else begin
                    if (lo_q != CNT_MAX) lo_q <= lo_q + CNT_ONE;
                end
            end
        end
    end

    assign present = have_per_q && ({1'b0, idle_q} <= {per_q, 1'b0});

    // R7: the reported pulse width changes only when a full period closes
    assert_width_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(pulse_len));

endmodule

// File: rtl/vtp_span.sv
// Back porch, front porch and active run length along one axis.
module vtp_span #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sync_act,
    input  logic             act,
    output logic [CNT_W-1:0] back_len,
    output logic [CNT_W-1:0] front_len,
    output logic [CNT_W-1:0] act_len,
    output logic             act_end
);
    localparam logic [CNT_W-1:0] CNT_ONE = 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] bp_cnt_q, fp_cnt_q, len_cnt_q;
    logic             bp_arm_q, fp_arm_q, act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_cnt_q  <= '0;
            fp_cnt_q  <= '0;
            len_cnt_q <= '0;
            bp_arm_q  <= 1'b0;
            fp_arm_q  <= 1'b0;
            act_q     <= 1'b0;
            back_len  <= '0;
            front_len <= '0;
            act_len   <= '0;
            act_end   <= 1'b0;
        end else begin
            act_end <= 1'b0;
            if (tick) begin
                act_q <= act;
                if (act) begin
                    if (!act_q)
                        len_cnt_q <= CNT_ONE;
                    else if (len_cnt_q != CNT_MAX)
                        len_cnt_q <= len_cnt_q + CNT_ONE;
                end else if (act_q) begin
                    act_len <= len_cnt_q;
                    act_end <= 1'b1;
                end
                if (sync_act) begin
                    bp_cnt_q <= '0;
                    bp_arm_q <= 1'b1;
                    if (fp_arm_q) begin
                        front_len <= fp_cnt_q;
                        fp_arm_q  <= 1'b0;
                    end
                end else if (act) begin
                    if (bp_arm_q) begin
                        back_len <= bp_cnt_q;
                        bp_arm_q <= 1'b0;
                    end
                    fp_cnt_q <= '0;
                    fp_arm_q <= 1'b1;
                end else begin
                    if (bp_arm_q && bp_cnt_q != CNT_MAX) bp_cnt_q <= bp_cnt_q + CNT_ONE;
                    if (fp_arm_q && fp_cnt_q != CNT_MAX) fp_cnt_q <= fp_cnt_q + CNT_ONE;
                end
            end
        end
    end

    // R8: porch results move only on a sample of this axis
    assert_porch_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(back_len) && $stable(front_len)));

endmodule

// File: rtl/vtp_link_fsm.sv
// Stream-present detector.
module vtp_link_fsm
    import vtp_pkg::*;
#(
    parameter int QW          = 16,
    parameter int CLK_TIMEOUT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_lock,
    input  logic          tick,
    input  logic          de,
    input  logic [QW-1:0] quiet_max,
    output logic          stream_ok
);
    localparam int GAP_W = $clog2(CLK_TIMEOUT + 1);
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(CLK_TIMEOUT);
    localparam logic [GAP_W-1:0] GAP_ONE = 1;
    localparam logic [QW-1:0]    Q_ONE   = 1;
    localparam logic [QW-1:0]    Q_MAX   = '1;

    link_state_t   state_q, state_d;
    logic [GAP_W-1:0] gap_q;
    logic [QW-1:0]    quiet_q;
    logic             de_q, de_seen_q;
    logic             de_edge, running, activity_ok;

    assign de_edge     = tick && de_seen_q && (de != de_q);
    assign running     = gap_q < GAP_LIM;
    assign activity_ok = running && (quiet_q < quiet_max);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q     <= GAP_LIM;
            quiet_q   <= '0;
            de_q      <= 1'b0;
            de_seen_q <= 1'b0;
        end else begin
            if (tick) begin
                gap_q     <= '0;
                de_q      <= de;
                de_seen_q <= 1'b1;
            end else if (gap_q != GAP_LIM) begin
                gap_q <= gap_q + GAP_ONE;
            end
            if (de_edge)
                quiet_q <= '0;
            else if (tick && quiet_q != Q_MAX)
                quiet_q <= quiet_q + Q_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_NOLINK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_NOLINK: if (link_lock) state_d = LS_SEARCH;
            LS_SEARCH: begin
                if (!link_lock)                  state_d = LS_NOLINK;
                else if (activity_ok && de_edge) state_d = LS_STREAM;
            end
            LS_STREAM: begin
                if (!link_lock)        state_d = LS_NOLINK;
                else if (!activity_ok) state_d = LS_SEARCH;
            end
            default: state_d = LS_NOLINK;
        endcase
    end

    always_comb begin
        stream_ok = (state_q == LS_STREAM);
    end

    // R1: streaming implies lock was present on the previous clock
    assert_lock_needed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_STREAM) |-> $past(link_lock));

    // R2: a quiet data enable or stalled strobe leaves streaming next cycle
    assert_quiet_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_STREAM && link_lock && !activity_ok) |=> (state_q == LS_SEARCH));

endmodule

// File: rtl/vid_timing_probe.sv
module vid_timing_probe
    import vtp_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int PER_W       = 20,
    parameter int QW          = 16,
    parameter int CLK_TIMEOUT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             link_lock,
    input  logic             de,
    input  logic             hsync,
    input  logic             vsync,
    input  logic [QW-1:0]    de_quiet_max,
    output logic             stream_ok,
    output logic [CNT_W-1:0] act_width,
    output logic [CNT_W-1:0] act_height,
    output logic [1:0]       hs_code,
    output logic [1:0]       vs_code,
    output logic [CNT_W-1:0] hs_width,
    output logic [CNT_W-1:0] vs_width,
    output logic [CNT_W-1:0] h_back,
    output logic [CNT_W-1:0] h_front,
    output logic [CNT_W-1:0] v_back,
    output logic [CNT_W-1:0] v_front
);
    localparam int NAX = 2;   // axis 0: horizontal, axis 1: vertical

    logic             pr_tick    [NAX];
    logic             pr_level   [NAX];
    logic             pr_present [NAX];
    logic             pr_high    [NAX];
    logic [CNT_W-1:0] pr_pulse   [NAX];
    logic             sp_tick    [NAX];
    logic             sp_sync    [NAX];
    logic             sp_act     [NAX];
    logic [CNT_W-1:0] sp_back    [NAX];
    logic [CNT_W-1:0] sp_front   [NAX];
    logic [CNT_W-1:0] sp_len     [NAX];
    logic             sp_end     [NAX];

    logic hs_act, vs_act, hs_act_q, line_stb;
    logic line_vs_q, line_de_q, frame_stb_q;

    assign hs_act   = pr_present[0] && (pr_high[0] ? hsync : !hsync);
    assign vs_act   = pr_present[1] && (pr_high[1] ? vsync : !vsync);
    assign line_stb = pix_en && hs_act && !hs_act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_act_q  <= 1'b0;
            line_vs_q <= 1'b0;
            line_de_q <= 1'b0;
        end else if (pix_en) begin
            hs_act_q <= hs_act;
            if (line_stb) begin
                line_vs_q <= vs_act;
                line_de_q <= de;
            end else if (de) begin
                line_de_q <= 1'b1;
            end
        end
    end

    assign pr_tick[0]  = pix_en;
    assign pr_level[0] = hsync;
    assign pr_tick[1]  = line_stb;
    assign pr_level[1] = vsync;
    assign sp_tick[0]  = pix_en;
    assign sp_sync[0]  = hs_act;
    assign sp_act[0]   = de;
    assign sp_tick[1]  = line_stb;
    assign sp_sync[1]  = line_vs_q;
    assign sp_act[1]   = line_de_q;

    for (genvar g = 0; g < NAX; g++) begin : g_axis
        vtp_sync_probe #(.CNT_W(CNT_W), .PER_W(PER_W)) i_probe (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (pr_tick[g]),
            .level     (pr_level[g]),
            .present   (pr_present[g]),
            .act_high  (pr_high[g]),
            .pulse_len (pr_pulse[g])
        );
        vtp_span #(.CNT_W(CNT_W)) i_span (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (sp_tick[g]),
            .sync_act  (sp_sync[g]),
            .act       (sp_act[g]),
            .back_len  (sp_back[g]),
            .front_len (sp_front[g]),
            .act_len   (sp_len[g]),
            .act_end   (sp_end[g])
        );
    end

    vtp_link_fsm #(.QW(QW), .CLK_TIMEOUT(CLK_TIMEOUT)) i_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_lock (link_lock),
        .tick      (pix_en),
        .de        (de),
        .quiet_max (de_quiet_max),
        .stream_ok (stream_ok)
    );

    sync_code_t hs_code_q, vs_code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_stb_q <= 1'b0;
            act_width   <= '0;
            act_height  <= '0;
            hs_width    <= '0;
            vs_width    <= '0;
            h_back      <= '0;
            h_front     <= '0;
            v_back      <= '0;
            v_front     <= '0;
            hs_code_q   <= SYNC_NONE;
            vs_code_q   <= SYNC_NONE;
        end else begin
            frame_stb_q <= sp_end[1];
            if (frame_stb_q) begin
                act_width  <= sp_len[0];
                act_height <= sp_len[1];
                hs_width   <= pr_pulse[0];
                vs_width   <= pr_pulse[1];
                h_back     <= sp_back[0];
                h_front    <= sp_front[0];
                v_back     <= sp_back[1];
                v_front    <= sp_front[1];
                hs_code_q  <= !pr_present[0] ? SYNC_NONE : (pr_high[0] ? SYNC_HIGH : SYNC_LOW);
                vs_code_q  <= !pr_present[1] ? SYNC_NONE : (pr_high[1] ? SYNC_HIGH : SYNC_LOW);
            end
        end
    end

    assign hs_code = hs_code_q;
    assign vs_code = vs_code_q;

    // R10: the reported set moves only on the frame strobe
    assert_hold_between_frames_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb_q |=> ($stable(act_width) && $stable(act_height) && $stable(v_front)
                          && $stable(hs_code) && $stable(vs_code)));

    // R6: the sync status codes never take the unused value
    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_code != 2'd3) && (vs_code != 2'd3));

endmodule

// File: tb/test_vid_timing_probe.sv
module test_vid_timing_probe;
    localparam int CNT_W = 12;
    localparam int QW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b0;
    logic link_lock = 1'b0;
    logic de = 1'b0;
    logic hsync = 1'b0;
    logic vsync = 1'b0;
    logic [QW-1:0] quiet_max = 16'd400;

    logic             stream_ok;
    logic [CNT_W-1:0] act_width, act_height, hs_width, vs_width;
    logic [CNT_W-1:0] h_back, h_front, v_back, v_front;
    logic [1:0]       hs_code, vs_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    vid_timing_probe #(.CNT_W(CNT_W), .QW(QW), .CLK_TIMEOUT(16)) i_vid_timing_probe (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .link_lock(link_lock),
        .de(de), .hsync(hsync), .vsync(vsync), .de_quiet_max(quiet_max),
        .stream_ok(stream_ok), .act_width(act_width), .act_height(act_height),
        .hs_code(hs_code), .vs_code(vs_code), .hs_width(hs_width), .vs_width(vs_width),
        .h_back(h_back), .h_front(h_front), .v_back(v_back), .v_front(v_front)
    );

    // hsw, hbp, ha, hfp, vsw, vbp, va, vfp, hs active-high, vs active-high
    localparam int VEC [4][10] = '{
        '{3, 4, 10, 5, 2, 3, 6, 2, 1, 1},
        '{2, 6, 12, 3, 1, 2, 5, 3, 0, 1},
        '{5, 2,  8, 4, 3, 1, 4, 2, 1, 0},
        '{1, 3, 16, 2, 2, 2, 7, 1, 0, 0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pix_en = 1'b0; de = 1'b0; hsync = 1'b0; vsync = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // vs_hold: 0 normal, 1 vertical sync frozen high
    task automatic run_frames(input int v, input int nfr, input int vs_hold);
        int ht, vt;
        ht = VEC[v][0] + VEC[v][1] + VEC[v][2] + VEC[v][3];
        vt = VEC[v][4] + VEC[v][5] + VEC[v][6] + VEC[v][7];
        for (int f = 0; f < nfr; f++) begin
            for (int l = 0; l < vt; l++) begin
                for (int p = 0; p < ht; p++) begin
                    bit h_on, v_on, d_on;
                    h_on = (p < VEC[v][0]);
                    v_on = (l < VEC[v][4]);
                    d_on = (l >= VEC[v][4] + VEC[v][5]) && (l < VEC[v][4] + VEC[v][5] + VEC[v][6])
                        && (p >= VEC[v][0] + VEC[v][1]) && (p < VEC[v][0] + VEC[v][1] + VEC[v][2]);
                    pix_en = 1'b1;
                    de     = d_on;
                    hsync  = VEC[v][8] != 0 ? h_on : !h_on;
                    vsync  = (vs_hold != 0) ? 1'b1 : (VEC[v][9] != 0 ? v_on : !v_on);
                    @(negedge clk);
                end
            end
        end
    endtask

    task automatic check_set(input int v);
        chk("R4 width",   int'(act_width),  VEC[v][2]);
        chk("R4 height",  int'(act_height), VEC[v][6]);
        chk("R5 hs code", int'(hs_code),    VEC[v][8]);
        chk("R5 vs code", int'(vs_code),    VEC[v][9]);
        chk("R7 hs width", int'(hs_width),  VEC[v][0]);
        chk("R7 vs width", int'(vs_width),  VEC[v][4]);
        chk("R8 h back",  int'(h_back),     VEC[v][1]);
        chk("R8 h front", int'(h_front),    VEC[v][3]);
        chk("R9 v back",  int'(v_back),     VEC[v][5]);
        chk("R9 v front", int'(v_front),    VEC[v][7]);
        chk("R2 stream present", int'(stream_ok), 1);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired before the end of the test sequence");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        link_lock = 1'b1;
        do_reset();
        // R10 reset state, R6 codes absent at reset
        chk("R10 reset stream", int'(stream_ok), 0);
        chk("R10 reset width",  int'(act_width), 0);
        chk("R10 reset h back", int'(h_back), 0);
        chk("R6 reset hs code", int'(hs_code), 2);
        chk("R6 reset vs code", int'(vs_code), 2);

        // table of configurations, one loop
        for (int v = 0; v < 4; v++) begin
            do_reset();
            run_frames(v, 5, 0);
            repeat (3) @(negedge clk);
            check_set(v);
        end

        // R2: data enable stalls; set holds (R10)
        de = 1'b0; hsync = 1'b1; vsync = 1'b1; pix_en = 1'b1;
        repeat (500) @(negedge clk);
        chk("R2 stream after quiet de", int'(stream_ok), 0);
        chk("R10 width held", int'(act_width), VEC[3][2]);
        chk("R10 height held", int'(act_height), VEC[3][6]);
        run_frames(3, 2, 0);
        chk("R2 stream recovered", int'(stream_ok), 1);

        // R3: pixel strobe stops
        pix_en = 1'b0;
        repeat (40) @(negedge clk);
        chk("R3 stream after strobe stop", int'(stream_ok), 0);
        run_frames(3, 1, 0);
        chk("R3 stream recovered", int'(stream_ok), 1);

        // R1: lock removed
        link_lock = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 stream without lock", int'(stream_ok), 0);
        run_frames(3, 1, 0);
        chk("R1 stream stays low without lock", int'(stream_ok), 0);
        link_lock = 1'b1;

        // R6: vertical sync never toggles from reset
        do_reset();
        run_frames(0, 5, 1);
        repeat (3) @(negedge clk);
        chk("R6 vs absent from reset", int'(vs_code), 2);
        chk("R4 height without vsync", int'(act_height), VEC[0][6]);
        chk("R5 hs code with vsync absent", int'(hs_code), 1);

        // R6: vertical sync disappears after running
        do_reset();
        run_frames(1, 4, 0);
        repeat (3) @(negedge clk);
        chk("R5 vs code before loss", int'(vs_code), 1);
        run_frames(1, 5, 1);
        repeat (3) @(negedge clk);
        chk("R6 vs code after loss", int'(vs_code), 2);
        chk("R4 height after vsync loss", int'(act_height), VEC[1][6]);
        chk("R4 width after vsync loss", int'(act_width), VEC[1][2]);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule